// File: doc/BRIEF.md
# Four-Line Serial Register Controller

This block is the host-side register file and interrupt source for a serial controller that multiplexes four lines. A host reaches four 16-bit registers over a single-cycle, word-addressed read/write bus: control and status, receive buffer (line parameters on write), transmit enable, and modem status (transmit data on write). Reads return data combinationally in the access cycle. Register effects show from the next cycle.

A one-cycle tick strobe drives the timed side. If master scan is on and no line is waiting for data, a tick looks for the next line whose bit is set in the transmit enable register. The search is round robin and starts after the line picked last time. The chosen line number goes into the status register. A tick that finds a transmit line does not flag received data in that same tick. Otherwise a tick flags received data whenever the external receive queue is not empty. Reading the receive buffer pops one entry from that queue. Writing transmit data sends one byte out on the line that the status register names.

Top module: `quad_line_regs`

## Requirements
- R1: After reset, control/status reads 0x8020 (transmit-ready at bit 15 and master scan at bit 5), transmit enable (offset 0x10) reads 0x0000, and `irq` is low.
- R2: A control/status write (offset 0x00) changes only bit 14 (transmit interrupt enable), bit 6 (receive interrupt enable), bit 5 (master scan), bit 4 (clear) and bit 3 (maintenance). When the write leaves master scan at 0, transmit-ready (bit 15) and receive-done (bit 7) are also cleared. While master scan is 0, neither of those two bits is ever set.
- R3: The clear bit (bit 4) drops on every register access, so it always reads back as 0, even right after a write of 1.
- R4: A tick with master scan 1 and transmit-ready 0 checks lines last+1, last+2, last+3 and last in that order, modulo 4. At the first line whose transmit enable bit (bit n for line n) is set, it sets transmit-ready and writes the line number into bits 9:8. If no line is enabled, nothing changes. After reset, "last" is line 0.
- R5: A tick that sets transmit-ready leaves receive-done at 0. Any other tick sets receive-done to (queue non-empty AND master scan).
- R6: `irq` is set in the cycle after a tick if that tick set transmit-ready while bit 14 is 1, or set receive-done while bit 6 is 1. Only a tick raises `irq`.
- R7: A transmit enable write stores the full 16-bit word and clears both transmit-ready and `irq`.
- R8: A write to offset 0x18 pulses `tx_strobe` in that same cycle, with `tx_byte` = write data bits 7:0 and `tx_line` = control/status bits 9:8. It also clears transmit-ready and `irq`.
- R9: A read of offset 0x08 returns {bit 15 = valid, bits 9:8 = line, bits 7:0 = byte} taken from the queue head, and pops that entry. It also clears receive-done and `irq`. With the queue empty it returns 0x0000 and pops nothing.
- R10: A read of offset 0x18 returns the parameter MSR_VALUE (default 0x0C0C). Other offsets read 0x0000, and writes to them, or to 0x08, change no register.
- R11: When a tick and a register access fall in the same cycle, the tick is applied first and the access effect is applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| tick | input | 1 | One-cycle scan strobe |
| rxq_nempty | input | 1 | Receive queue holds an entry |
| rxq_data | input | 8 | Byte at the queue head |
| rxq_line | input | 2 | Line number at the queue head |
| rxq_pop | output | 1 | Remove the queue head |
| tx_strobe | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Byte to send |
| tx_line | output | 2 | Line to send on |
| irq | output | 1 | Interrupt request |

## Verification
Read data, `rxq_pop` and the transmit strobe are combinational in the access cycle. The bench samples them two nanoseconds after it drives the access, which is well before the closing edge. Register changes made by a write, a pop or a tick, and the registered `irq`, are due one edge later. The bench checks them by reading back in a later access, or by sampling `irq` one nanosecond after that edge. Tick-versus-access collisions and scan wrap-around get their own directed sequences, each with the status value worked out ahead.

// File: rtl/qlr_pkg.sv
package qlr_pkg;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LINE_N  = 4;
    localparam int LINE_W  = $clog2(LINE_N);

    // status bit positions
    localparam int B_TRDY  = 15;
    localparam int B_TIE   = 14;
    localparam int B_LNHI  = 9;
    localparam int B_LNLO  = 8;
    localparam int B_RDONE = 7;
    localparam int B_RIE   = 6;
    localparam int B_MSE   = 5;
    localparam int B_CLR   = 4;
    localparam int B_MAINT = 3;
    localparam int B_VALID = 15;

    localparam logic [DATA_W-1:0] CSR_WMASK =
        (DATA_W'(1) << B_TIE) | (DATA_W'(1) << B_RIE) | (DATA_W'(1) << B_MSE) |
        (DATA_W'(1) << B_CLR) | (DATA_W'(1) << B_MAINT);
    localparam logic [DATA_W-1:0] CSR_RESET =
        (DATA_W'(1) << B_TRDY) | (DATA_W'(1) << B_MSE);

    localparam logic [7:0] OFF_CSR  = 8'h00;
    localparam logic [7:0] OFF_RBUF = 8'h08;
    localparam logic [7:0] OFF_TCR  = 8'h10;
    localparam logic [7:0] OFF_MSR  = 8'h18;

    typedef struct packed {
        logic [DATA_W-1:0] csr;
        logic [DATA_W-1:0] tcr;
        logic [LINE_W-1:0] scan;
        logic              irq;
    } qlr_state_t;

    typedef struct packed {
        logic any;
        logic wr_csr;
        logic wr_tcr;
        logic wr_tdr;
        logic rd_csr;
        logic rd_rbuf;
        logic rd_tcr;
        logic rd_msr;
    } qlr_hit_t;
endpackage

// File: rtl/qlr_bus_decode.sv
module qlr_bus_decode
    import qlr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output qlr_hit_t          hit
);
    logic at_csr, at_rbuf, at_tcr, at_msr;

    always_comb begin
        at_csr  = (addr == ADDR_W'(OFF_CSR));
        at_rbuf = (addr == ADDR_W'(OFF_RBUF));
        at_tcr  = (addr == ADDR_W'(OFF_TCR));
        at_msr  = (addr == ADDR_W'(OFF_MSR));
        hit.any     = sel;
        hit.wr_csr  = sel &&  we && at_csr;
        hit.wr_tcr  = sel &&  we && at_tcr;
        hit.wr_tdr  = sel &&  we && at_msr;
        hit.rd_csr  = sel && !we && at_csr;
        hit.rd_rbuf = sel && !we && at_rbuf;
        hit.rd_tcr  = sel && !we && at_tcr;
        hit.rd_msr  = sel && !we && at_msr;
    end
endmodule

// File: rtl/qlr_rr_pick.sv
module qlr_rr_pick #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] en,
    input  logic [W-1:0] last,
    output logic         found,
    output logic [W-1:0] pick
);
    // candidate k is the line k+1 places after the last one (N is a power of two)
    logic [W-1:0] cand [N];
    logic [N-1:0] cand_en;

    for (genvar k = 0; k < N; k++) begin : g_cand
        assign cand[k]    = last + W'(k + 1);
        assign cand_en[k] = en[cand[k]];
    end

    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand_en[k]) begin
                found = 1'b1;
                pick  = cand[k];
            end
        end
    end
endmodule

// File: rtl/quad_line_regs.sv
module quad_line_regs
    import qlr_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter logic [DATA_W-1:0] MSR_VALUE = 16'h0C0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              tick,
    input  logic              rxq_nempty,
    input  logic [7:0]        rxq_data,
    input  logic [1:0]        rxq_line,
    output logic              rxq_pop,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    output logic [1:0]        tx_line,
    output logic              irq
);
    qlr_state_t st_d, st_q;
    qlr_hit_t   hit;

    logic              rr_found;
    logic [LINE_W-1:0] rr_pick;
    logic              tx_set;

    logic csr_trdy, csr_rdone, csr_mse, tcr_wr;

    qlr_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .hit  (hit)
    );

    qlr_rr_pick #(.N(LINE_N)) pick_i (
        .en    (st_q.tcr[LINE_N-1:0]),
        .last  (st_q.scan),
        .found (rr_found),
        .pick  (rr_pick)
    );

    always_comb begin
        st_d   = st_q;
        tx_set = 1'b0;

        // timed side first
        if (tick) begin
            if (st_q.csr[B_MSE] && !st_q.csr[B_TRDY] && rr_found) begin
                tx_set                    = 1'b1;
                st_d.csr[B_TRDY]          = 1'b1;
                st_d.csr[B_LNHI:B_LNLO]   = rr_pick;
                st_d.scan                 = rr_pick;
                if (st_q.csr[B_TIE])
                    st_d.irq = 1'b1;
            end
            st_d.csr[B_RDONE] = !tx_set && rxq_nempty && st_q.csr[B_MSE];
            if (st_d.csr[B_RDONE] && st_q.csr[B_RIE])
                st_d.irq = 1'b1;
        end

        // host access on top
        if (hit.any)
            st_d.csr[B_CLR] = 1'b0;
        if (hit.wr_csr) begin
            st_d.csr = (st_d.csr & ~CSR_WMASK) | (bus_wdata & CSR_WMASK);
            if (!bus_wdata[B_MSE]) begin
                st_d.csr[B_TRDY]  = 1'b0;
                st_d.csr[B_RDONE] = 1'b0;
            end
        end
        if (hit.wr_tcr) begin
            st_d.tcr         = bus_wdata;
            st_d.csr[B_TRDY] = 1'b0;
            st_d.irq         = 1'b0;
        end
        if (hit.wr_tdr) begin
            st_d.csr[B_TRDY] = 1'b0;
            st_d.irq         = 1'b0;
        end
        if (hit.rd_rbuf) begin
            st_d.csr[B_RDONE] = 1'b0;
            st_d.irq          = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.csr  <= CSR_RESET;
            st_q.tcr  <= '0;
            st_q.scan <= '0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit.rd_csr) begin
            bus_rdata        = st_q.csr;
            bus_rdata[B_CLR] = 1'b0;
        end else if (hit.rd_tcr) begin
            bus_rdata = st_q.tcr;
        end else if (hit.rd_msr) begin
            bus_rdata = MSR_VALUE;
        end else if (hit.rd_rbuf && rxq_nempty) begin
            bus_rdata[B_VALID]     = 1'b1;
            bus_rdata[B_LNHI:B_LNLO] = rxq_line;
            bus_rdata[BYTE_W-1:0]  = rxq_data;
        end
    end

    assign rxq_pop   = hit.rd_rbuf && rxq_nempty;
    assign tx_strobe = hit.wr_tdr;
    assign tx_byte   = bus_wdata[BYTE_W-1:0];
    assign tx_line   = st_q.csr[B_LNHI:B_LNLO];
    assign irq       = st_q.irq;

    assign csr_trdy  = st_q.csr[B_TRDY];
    assign csr_rdone = st_q.csr[B_RDONE];
    assign csr_mse   = st_q.csr[B_MSE];
    assign tcr_wr    = hit.wr_tcr;
endmodule

// File: rtl/qlr_checker.sv
module qlr_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic irq,
    input logic rxq_pop,
    input logic tx_strobe,
    input logic tcr_wr,
    input logic csr_trdy,
    input logic csr_rdone,
    input logic csr_mse
);
    assert_irq_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    assert_trdy_from_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_trdy) |-> $past(tick));

    assert_mse_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_mse |-> (!csr_trdy && !csr_rdone));

    assert_tcr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tcr_wr |=> (!csr_trdy && !irq));

    assert_tdr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> (!csr_trdy && !irq));

    assert_pop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |=> (!csr_rdone && !irq));
endmodule

bind quad_line_regs qlr_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .irq       (irq),
    .rxq_pop   (rxq_pop),
    .tx_strobe (tx_strobe),
    .tcr_wr    (tcr_wr),
    .csr_trdy  (csr_trdy),
    .csr_rdone (csr_rdone),
    .csr_mse   (csr_mse)
);

// File: tb/quad_line_regs_tb.sv
module quad_line_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxq_nempty, rxq_pop, tx_strobe, irq;
    logic [7:0]  rxq_data, tx_byte;
    logic [1:0]  rxq_line, tx_line;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // receive queue model
    logic [7:0] qc [16];
    logic [1:0] ql [16];
    logic [3:0] qw = '0, qr;
    assign rxq_nempty = (qw != qr);
    assign rxq_data   = qc[qr];
    assign rxq_line   = ql[qr];
    always @(posedge clk) begin
        if (!rst_n) qr <= '0;
        else if (rxq_pop) qr <= qr + 4'd1;
    end

    quad_line_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .rxq_nempty(rxq_nempty), .rxq_data(rxq_data),
        .rxq_line(rxq_line), .rxq_pop(rxq_pop), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .tx_line(tx_line), .irq(irq)
    );

    logic [15:0] rd_v;
    logic        cap_stb;
    logic [7:0]  cap_byte;
    logic [1:0]  cap_line;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input bit s, input bit w, input logic [4:0] a,
                       input logic [15:0] wd);
        @(negedge clk);
        tick = t; bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = wd;
        #2;
        rd_v = bus_rdata; cap_stb = tx_strobe; cap_byte = tx_byte; cap_line = tx_line;
        @(posedge clk);
        #1;
        tick = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d); cyc(0, 1, 1, a, d); endtask
    task automatic rd(input logic [4:0] a); cyc(0, 1, 0, a, '0); endtask
    task automatic tk(); cyc(1, 0, 0, '0, '0); endtask
    task automatic push(input logic [7:0] c, input logic [1:0] l);
        qc[qw] = c; ql[qw] = l; qw = qw + 4'd1;
    endtask

    // {kind(0 write,1 read,2 tick), req, addr, wdata, expected read}
    localparam int NV = 33;
    localparam logic [42:0] VEC [NV] = '{
        {2'd1, 4'd1,  5'h00, 16'h0000, 16'h8020},  // R1 reset status
        {2'd1, 4'd1,  5'h10, 16'h0000, 16'h0000},  // R1 enable reg zero
        {2'd0, 4'd7,  5'h10, 16'h000A, 16'h0000},
        {2'd1, 4'd7,  5'h00, 16'h0000, 16'h0020},  // R7 ready cleared
        {2'd1, 4'd7,  5'h10, 16'h0000, 16'h000A},  // R7 stored
        {2'd2, 4'd4,  5'h00, 16'h0000, 16'h0000},
        {2'd1, 4'd4,  5'h00, 16'h0000, 16'h8120},  // R4 line 1
        {2'd0, 4'd8,  5'h18, 16'h1241, 16'h0000},
        {2'd1, 4'd8,  5'h00, 16'h0000, 16'h0120},  // R8 ready cleared
        {2'd2, 4'd4,  5'h00, 16'h0000, 16'h0000},
        {2'd1, 4'd4,  5'h00, 16'h0000, 16'h8320},  // R4 skips 2, picks 3
        {2'd0, 4'd8,  5'h18, 16'h0000, 16'h0000},
        {2'd2, 4'd4,  5'h00, 16'h0000, 16'h0000},
        {2'd1, 4'd4,  5'h00, 16'h0000, 16'h8120},  // R4 wraps to 1
        {2'd0, 4'd2,  5'h00, 16'hFFFF, 16'h0000},
        {2'd1, 4'd3,  5'h00, 16'h0000, 16'hC168},  // R2 R3 masked write, clear reads 0
        {2'd0, 4'd2,  5'h00, 16'h0000, 16'h0000},
        {2'd1, 4'd2,  5'h00, 16'h0000, 16'h0100},  // R2 scan off drops ready
        {2'd2, 4'd2,  5'h00, 16'h0000, 16'h0000},
        {2'd1, 4'd2,  5'h00, 16'h0000, 16'h0100},  // R2 no scan while off
        {2'd0, 4'd2,  5'h00, 16'h0020, 16'h0000},
        {2'd0, 4'd7,  5'h10, 16'h0000, 16'h0000},
        {2'd2, 4'd4,  5'h00, 16'h0000, 16'h0000},
        {2'd1, 4'd4,  5'h00, 16'h0000, 16'h0120},  // R4 nothing enabled
        {2'd1, 4'd10, 5'h18, 16'h0000, 16'h0C0C},  // R10 modem status
        {2'd1, 4'd10, 5'h04, 16'h0000, 16'h0000},  // R10 unmapped read
        {2'd0, 4'd10, 5'h04, 16'hFFFF, 16'h0000},
        {2'd0, 4'd10, 5'h08, 16'hFFFF, 16'h0000},
        {2'd1, 4'd10, 5'h00, 16'h0000, 16'h0120},  // R10 writes ignored
        {2'd1, 4'd10, 5'h10, 16'h0000, 16'h0000},
        {2'd1, 4'd9,  5'h08, 16'h0000, 16'h0000},  // R9 empty read
        {2'd1, 4'd9,  5'h00, 16'h0000, 16'h0120},
        {2'd1, 4'd10, 5'h1C, 16'h0000, 16'h0000}
    };

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 irq", {15'd0, irq}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][42:41])
                2'd0: wr(VEC[i][36:32], VEC[i][31:16]);
                2'd1: begin
                    rd(VEC[i][36:32]);
                    check($sformatf("R%0d vec%0d", VEC[i][40:37], i), rd_v, VEC[i][15:0]);
                end
                default: tk();
            endcase
        end

        // R8 transmit strobe on the scanned line
        wr(5'h10, 16'h0004);
        tk();                                   // from last 1: picks 2
        wr(5'h18, 16'h33A5);
        check("R8 strobe", {15'd0, cap_stb}, 16'd1);
        check("R8 byte", {8'd0, cap_byte}, 16'h00A5);
        check("R8 line", {14'd0, cap_line}, 16'd2);
        rd(5'h00);
        check("R8 idle strobe", {15'd0, cap_stb}, 16'd0);

        // R6 transmit interrupt, R7 clears it
        wr(5'h00, 16'h4020);
        tk();                                   // 3,0,1 off, 2 on
        check("R6 irq tx", {15'd0, irq}, 16'd1);
        rd(5'h00);
        check("R6 status", rd_v, 16'hC220);
        wr(5'h10, 16'h0000);
        check("R7 irq drop", {15'd0, irq}, 16'd0);

        // R5 R9 receive path
        push(8'h33, 2'd1);
        push(8'h44, 2'd3);
        wr(5'h00, 16'h0060);
        tk();
        check("R6 irq rx", {15'd0, irq}, 16'd1);
        rd(5'h00);
        check("R5 rdone", rd_v, 16'h02E0);
        rd(5'h08);
        check("R9 head", rd_v, 16'h8133);
        check("R9 irq drop", {15'd0, irq}, 16'd0);
        rd(5'h00);
        check("R9 rdone drop", rd_v, 16'h0260);
        rd(5'h08);
        check("R9 second", rd_v, 16'h8344);
        rd(5'h08);
        check("R9 empty", rd_v, 16'h0000);

        // R5 transmit scan wins over receive
        push(8'h55, 2'd0);
        wr(5'h10, 16'h0001);
        tk();                                   // 3 off, 0 on
        rd(5'h00);
        check("R5 tx first", rd_v, 16'h8060);
        check("R5 no irq", {15'd0, irq}, 16'd0);
        tk();
        rd(5'h00);
        check("R5 rx next", rd_v, 16'h80E0);
        check("R6 irq rx2", {15'd0, irq}, 16'd1);
        rd(5'h08);
        check("R9 third", rd_v, 16'h8055);

        // R11 tick and enable write in one cycle
        wr(5'h10, 16'h0000);
        cyc(1, 1, 1, 5'h10, 16'h0001);
        rd(5'h00);
        check("R11 access wins", rd_v, 16'h0060);
        check("R11 irq", {15'd0, irq}, 16'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule